// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach a slow, byte-laned peripheral register space through a small window of six word registers. Instead of mapping every inner register onto the host bus, the host loads a control word naming an inner address, a transfer direction and the byte lanes to touch. The bridge then runs exactly one transfer on the inner side. While that transfer is in flight, a busy flag in the control word is set and further accesses are held off. Read results come back through the lower data register.

A write goes in two steps. First the host loads the control word with the direction bit clear, then it writes the value to the lower data register, and that second write launches the transfer. A read also goes in two steps. The host loads the control word with the direction bit set, which launches the transfer at once. It then polls until busy drops and reads the lower data register.

The bridge also collects two interrupt sources into a flag register with a matching enable mask. One source is the inner subsystem's request line, taken on its rising edge. The other is the completion of an inner transfer. Flags are cleared by writing ones to them.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset the control word reads 0 (busy clear), the lower data, flag and enable registers read 0 and `irq` is low.
- R2: The identification register at byte offset 0x00 reads the parameter `ID_VALUE`. The upper data register (0x0C) and the enable register (0x10, bits 1:0) read back what was written. The control word (0x04) reads back inner address in bits 7:0, lower lane enables in 19:16 (bit 16 = byte 0), upper lane enables in 23:20, direction in 24, size in 25, and busy in 31.
- R3: A control write with bit 24 set, accepted while idle, starts a read transfer. From the next clock edge, busy and `innerReq` are high, `innerWe` is low, and `innerAddr` and `innerBe` carry control bits 7:0 and 19:16.
- R4: A control write with bit 24 clear starts nothing. A later lower-data write (0x08) starts a write transfer, with `innerWe` high and `innerWdata` equal to the written value. A lower-data write while the stored direction is read only loads the register.
- R5: Busy and `innerReq` stay high until the edge that samples `innerAck` high, and they are low from the next edge. Only one transfer is outstanding.
- R6: When a read transfer completes, each lower-data byte whose lane enable is set takes the matching byte of `innerRdata`. Bytes whose lane is disabled keep their value.
- R7: Writes to control, lower data and upper data while busy have no effect. A lower-data read during a transfer returns the value from before the transfer.
- R8: Flag bit 1 is set by a rising edge of `innerIrq`. A level that stays high does not set it again after it is cleared.
- R9: Flag bit 0 is set when an inner transfer completes.
- R10: Writing 1 to a flag bit (offset 0x14) clears it, and writing 0 leaves it unchanged. A set event in the same cycle as the clear wins.
- R11: `irq` is high exactly when some flag bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSel | input | 1 | Host access strobe, one cycle per access |
| hostWrite | input | 1 | 1 = host write, 0 = host read |
| hostAddr | input | 5 | Host byte offset of the word register |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, valid with hostRdValid |
| hostRdValid | output | 1 | Read data valid, one cycle after a read access |
| innerReq | output | 1 | Inner transfer request, held until acknowledged |
| innerWe | output | 1 | Inner transfer direction, 1 = write |
| innerAddr | output | 8 | Inner register address |
| innerBe | output | 4 | Inner byte lane enables |
| innerWdata | output | 32 | Inner write data |
| innerAck | input | 1 | Inner transfer done, one-cycle pulse |
| innerRdata | input | 32 | Inner read data, valid with innerAck |
| innerIrq | input | 1 | Inner subsystem interrupt request |
| irq | output | 1 | Aggregated interrupt output |

## Verification
The assertions check the handshake on every cycle. A read-direction control write raises busy at the next edge. The request never appears without busy. Busy holds until the acknowledge and drops right after it. The control fields are frozen while busy. An enabled rising interrupt edge raises `irq`. Lane merging on read completion, write-data transport, the ignored-while-busy data writes and the set-over-clear rule need known data and arrive through the scenarios of the bench, whose model of the inner space has a fixed latency.

// File: rtl/ind_bridge_pkg.sv
package ind_bridge_pkg;
  localparam int HOST_AW = 5;
  localparam int LANES   = 4;
  localparam int DATA_W  = LANES * 8;
  localparam int INNER_AW = 8;
  localparam int FLAG_N  = 2;

  localparam logic [HOST_AW-1:0] OFF_ID   = 5'h00;
  localparam logic [HOST_AW-1:0] OFF_CTRL = 5'h04;
  localparam logic [HOST_AW-1:0] OFF_LOW  = 5'h08;
  localparam logic [HOST_AW-1:0] OFF_UP   = 5'h0C;
  localparam logic [HOST_AW-1:0] OFF_EN   = 5'h10;
  localparam logic [HOST_AW-1:0] OFF_FLAG = 5'h14;

  localparam int BIT_BUSY = 31;
  localparam int BIT_SIZE = 25;
  localparam int BIT_DIR  = 24;
  localparam int BEU_LSB  = 20;
  localparam int BEL_LSB  = 16;

  localparam int FLG_XFER = 0;
  localparam int FLG_SUB  = 1;

  typedef struct packed {
    logic ldCtrl;
    logic ldLow;
    logic ldUp;
    logic ldEn;
    logic clrFlag;
    logic start;
    logic done;
  } strobe_t;
endpackage

// File: rtl/ind_bridge_ctrl.sv
module ind_bridge_ctrl
  import ind_bridge_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostSel,
  input  logic               hostWrite,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               wrDir,
  input  logic               storedDir,
  input  logic               innerAck,
  output logic               busy,
  output strobe_t            stb
);
  typedef enum logic {IDLE, XFER} state_t;
  state_t state;

  logic wrHit, wrOpen;

  assign busy   = (state == XFER);
  assign wrHit  = hostSel && hostWrite;
  assign wrOpen = wrHit && !busy;

  always_comb begin
    stb         = '0;
    stb.ldCtrl  = wrOpen && (hostAddr == OFF_CTRL);
    stb.ldLow   = wrOpen && (hostAddr == OFF_LOW);
    stb.ldUp    = wrOpen && (hostAddr == OFF_UP);
    stb.ldEn    = wrHit  && (hostAddr == OFF_EN);
    stb.clrFlag = wrHit  && (hostAddr == OFF_FLAG);
    stb.start   = (stb.ldCtrl && wrDir) || (stb.ldLow && !storedDir);
    stb.done    = busy && innerAck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= IDLE;
    end else begin
      case (state)
        IDLE: if (stb.start) state <= XFER;
        XFER: if (innerAck)  state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ind_bridge_dp.sv
module ind_bridge_dp
  import ind_bridge_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h1D0B_0001
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic                busy,
  input  logic                hostSel,
  input  logic                hostWrite,
  input  logic [HOST_AW-1:0]  hostAddr,
  input  logic [DATA_W-1:0]   hostWdata,
  input  logic [DATA_W-1:0]   innerRdata,
  input  logic                innerIrq,
  output logic [DATA_W-1:0]   hostRdata,
  output logic                hostRdValid,
  output logic                storedDir,
  output logic [INNER_AW-1:0] innerAddr,
  output logic [LANES-1:0]    innerBe,
  output logic [DATA_W-1:0]   innerWdata,
  output logic                irq,
  output logic [24:0]         ctrlView,
  output logic [FLAG_N-1:0]   enView
);
  logic [INNER_AW-1:0] addrQ;
  logic [LANES-1:0]    beLowQ, beUpQ;
  logic                dirQ, sizeQ;
  logic [7:0]          lowByte [LANES];
  logic [DATA_W-1:0]   lowQ, upQ;
  logic [FLAG_N-1:0]   enQ, flagQ, flagSet;
  logic                irqPrev;
  logic [DATA_W-1:0]   ctrlWord, rdMux;

  // control word fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      beLowQ <= '0;
      beUpQ  <= '0;
      dirQ   <= 1'b0;
      sizeQ  <= 1'b0;
    end else if (stb.ldCtrl) begin
      addrQ  <= hostWdata[INNER_AW-1:0];
      beLowQ <= hostWdata[BEL_LSB +: LANES];
      beUpQ  <= hostWdata[BEU_LSB +: LANES];
      dirQ   <= hostWdata[BIT_DIR];
      sizeQ  <= hostWdata[BIT_SIZE];
    end
  end

  // lower data, one byte lane per generate slice
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lowByte[g] <= '0;
      end else if (stb.ldLow) begin
        lowByte[g] <= hostWdata[g*8 +: 8];
      end else if (stb.done && dirQ && beLowQ[g]) begin
        lowByte[g] <= innerRdata[g*8 +: 8];
      end
    end
    assign lowQ[g*8 +: 8] = lowByte[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upQ <= '0;
      enQ <= '0;
    end else begin
      if (stb.ldUp) upQ <= hostWdata;
      if (stb.ldEn) enQ <= hostWdata[FLAG_N-1:0];
    end
  end

  // interrupt flags: set events win over write-one-to-clear
  always_comb begin
    flagSet           = '0;
    flagSet[FLG_SUB]  = innerIrq && !irqPrev;
    flagSet[FLG_XFER] = stb.done;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ   <= '0;
      irqPrev <= 1'b0;
    end else begin
      irqPrev <= innerIrq;
      flagQ   <= (flagQ & ~(stb.clrFlag ? hostWdata[FLAG_N-1:0] : '0)) | flagSet;
    end
  end

  assign irq = |(flagQ & enQ);

  assign ctrlWord = {busy, 5'b0, sizeQ, dirQ, beUpQ, beLowQ, 8'b0, addrQ};

  always_comb begin
    case (hostAddr)
      OFF_ID:   rdMux = ID_VALUE;
      OFF_CTRL: rdMux = ctrlWord;
      OFF_LOW:  rdMux = lowQ;
      OFF_UP:   rdMux = upQ;
      OFF_EN:   rdMux = {{(DATA_W-FLAG_N){1'b0}}, enQ};
      OFF_FLAG: rdMux = {{(DATA_W-FLAG_N){1'b0}}, flagQ};
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdValid <= 1'b0;
      hostRdata   <= '0;
    end else begin
      hostRdValid <= hostSel && !hostWrite;
      if (hostSel && !hostWrite) hostRdata <= rdMux;
    end
  end

  assign storedDir  = dirQ;
  assign innerAddr  = addrQ;
  assign innerBe    = beLowQ;
  assign innerWdata = lowQ;
  assign ctrlView   = ctrlWord[24:0];
  assign enView     = enQ;
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import ind_bridge_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h1D0B_0001
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostSel,
  input  logic        hostWrite,
  input  logic [4:0]  hostAddr,
  input  logic [31:0] hostWdata,
  output logic [31:0] hostRdata,
  output logic        hostRdValid,
  output logic        innerReq,
  output logic        innerWe,
  output logic [7:0]  innerAddr,
  output logic [3:0]  innerBe,
  output logic [31:0] innerWdata,
  input  logic        innerAck,
  input  logic [31:0] innerRdata,
  input  logic        innerIrq,
  output logic        irq
);
  strobe_t           stb;
  logic              busy;
  logic              storedDir;
  logic [24:0]       ctrlView;
  logic [FLAG_N-1:0] enView;

  ind_bridge_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostSel   (hostSel),
    .hostWrite (hostWrite),
    .hostAddr  (hostAddr),
    .wrDir     (hostWdata[BIT_DIR]),
    .storedDir (storedDir),
    .innerAck  (innerAck),
    .busy      (busy),
    .stb       (stb)
  );

  ind_bridge_dp #(.ID_VALUE(ID_VALUE)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .busy        (busy),
    .hostSel     (hostSel),
    .hostWrite   (hostWrite),
    .hostAddr    (hostAddr),
    .hostWdata   (hostWdata),
    .innerRdata  (innerRdata),
    .innerIrq    (innerIrq),
    .hostRdata   (hostRdata),
    .hostRdValid (hostRdValid),
    .storedDir   (storedDir),
    .innerAddr   (innerAddr),
    .innerBe     (innerBe),
    .innerWdata  (innerWdata),
    .irq         (irq),
    .ctrlView    (ctrlView),
    .enView      (enView)
  );

  assign innerReq = busy;
  assign innerWe  = !storedDir;
endmodule

// File: rtl/ind_reg_bridge_chk.sv
module ind_reg_bridge_chk
  import ind_bridge_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        innerReq,
  input logic        innerAck,
  input logic        hostSel,
  input logic        hostWrite,
  input logic [4:0]  hostAddr,
  input logic        wrDirBit,
  input logic [24:0] ctrlView,
  input logic        innerIrq,
  input logic [1:0]  enView,
  input logic        irq
);
  p_read_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && hostSel && hostWrite && hostAddr == OFF_CTRL && wrDirBit) |=> busy);

  p_req_in_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    innerReq |-> busy);

  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !innerAck) |=> busy);

  p_ack_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && innerAck) |=> !busy);

  p_ctrl_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(ctrlView));

  p_sub_edge_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(innerIrq) && enView[1]) |=> irq);

  p_masked_r11: assert property (@(posedge clk) disable iff (!rstN)
    (enView == 2'b00) |-> !irq);
endmodule

bind ind_reg_bridge ind_reg_bridge_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .innerReq  (innerReq),
  .innerAck  (innerAck),
  .hostSel   (hostSel),
  .hostWrite (hostWrite),
  .hostAddr  (hostAddr),
  .wrDirBit  (hostWdata[24]),
  .ctrlView  (ctrlView),
  .innerIrq  (innerIrq),
  .enView    (enView),
  .irq       (irq)
);

// File: tb/sim_ind_reg_bridge.sv
module sim_ind_reg_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 6;
  localparam logic [31:0] ID_EXP = 32'h1D0B_0001;
  localparam logic [4:0] A_ID = 5'h00, A_CTRL = 5'h04, A_LOW = 5'h08,
                         A_UP = 5'h0C, A_EN = 5'h10, A_FLAG = 5'h14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostSel = 1'b0, hostWrite = 1'b0;
  logic [4:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic hostRdValid;
  logic innerReq, innerWe;
  logic [7:0] innerAddr;
  logic [3:0] innerBe;
  logic [31:0] innerWdata;
  logic innerAck = 1'b0;
  logic [31:0] innerRdata = '0;
  logic innerIrq = 1'b0;
  logic irq;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  logic [31:0] expQ[$];
  string tagQ[$];

  logic [7:0] mem [256][4];
  logic pend = 1'b0;
  int cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ind_reg_bridge u0 (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostRdValid(hostRdValid), .innerReq(innerReq), .innerWe(innerWe),
    .innerAddr(innerAddr), .innerBe(innerBe), .innerWdata(innerWdata),
    .innerAck(innerAck), .innerRdata(innerRdata), .innerIrq(innerIrq), .irq(irq)
  );

  // inner register space model, fixed latency
  always @(posedge clk) begin
    innerAck <= 1'b0;
    if (innerReq && !innerAck && !pend) begin
      pend <= 1'b1;
      cnt  <= LAT;
    end else if (pend) begin
      if (cnt == 0) begin
        pend     <= 1'b0;
        innerAck <= 1'b1;
        innerRdata <= {mem[innerAddr][3], mem[innerAddr][2], mem[innerAddr][1], mem[innerAddr][0]};
        if (innerWe) begin
          for (int k = 0; k < 4; k++)
            if (innerBe[k]) mem[innerAddr][k] <= innerWdata[k*8 +: 8];
        end
      end else begin
        cnt <= cnt - 1;
      end
    end
  end

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (hostRdValid) begin
      if (expQ.size() == 0) begin
        chkEq("scoreboard unexpected read", hostRdata, 32'h0);
      end else begin
        automatic string t = tagQ.pop_front();
        automatic logic [31:0] e = expQ.pop_front();
        chkEq(t, hostRdata, e);
      end
    end
  end

  task automatic hostWr(input logic [4:0] a, input logic [31:0] d);
    hostSel = 1'b1; hostWrite = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostSel = 1'b0; hostWrite = 1'b0;
  endtask

  task automatic hostRd(input logic [4:0] a, input logic [31:0] e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
    hostSel = 1'b1; hostWrite = 1'b0; hostAddr = a;
    @(negedge clk);
    hostSel = 1'b0;
  endtask

  task automatic waitDone();
    while (!innerAck) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nChecks++;
        nFail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
        finishRun();
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++)
      for (int k = 0; k < 4; k++) mem[i][k] = 8'h00;
    mem[8'h22][3] = 8'h44; mem[8'h22][2] = 8'h33; mem[8'h22][1] = 8'h22; mem[8'h22][0] = 8'h11;
    mem[8'h23][3] = 8'hAA; mem[8'h23][2] = 8'hBB; mem[8'h23][1] = 8'hCC; mem[8'h23][0] = 8'hDD;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chkEq("R1 irq after reset", {31'b0, irq}, 32'h0);
    hostRd(A_CTRL, 32'h0, "R1 control after reset");
    hostRd(A_LOW,  32'h0, "R1 lower data after reset");
    hostRd(A_FLAG, 32'h0, "R1 flags after reset");
    hostRd(A_EN,   32'h0, "R1 enables after reset");

    // R2 register map and read-back
    hostRd(A_ID, ID_EXP, "R2 identification");
    hostWr(A_UP, 32'hA5A5_1234);
    hostRd(A_UP, 32'hA5A5_1234, "R2 upper data readback");
    hostWr(A_EN, 32'h0000_0002);
    hostRd(A_EN, 32'h0000_0002, "R2 enable readback");
    hostWr(A_CTRL, 32'h02F0_0005);
    hostRd(A_CTRL, 32'h02F0_0005, "R2 size and upper lanes readback");

    // R4 write transfer
    hostWr(A_CTRL, 32'h000F_0010);
    chkEq("R4 no request on write-direction control", {31'b0, innerReq}, 32'h0);
    hostRd(A_CTRL, 32'h000F_0010, "R4 control stored, idle");
    hostWr(A_LOW, 32'hDEAD_BEEF);
    chkEq("R4 request after lower write", {31'b0, innerReq}, 32'h1);
    chkEq("R4 write direction", {31'b0, innerWe}, 32'h1);
    chkEq("R4 write data", innerWdata, 32'hDEAD_BEEF);
    hostRd(A_CTRL, 32'h800F_0010, "R5 busy visible during transfer");
    hostWr(A_CTRL, 32'h0000_0055);
    hostWr(A_LOW, 32'h1111_1111);
    hostWr(A_UP, 32'h2222_2222);
    waitDone();
    chkEq("R5 request dropped after ack", {31'b0, innerReq}, 32'h0);
    hostRd(A_CTRL, 32'h000F_0010, "R7 control write while busy ignored");
    hostRd(A_LOW, 32'hDEAD_BEEF, "R7 lower write while busy ignored");
    hostRd(A_UP, 32'hA5A5_1234, "R7 upper write while busy ignored");
    chkEq("R4 inner bytes written", {mem[8'h10][3], mem[8'h10][2], mem[8'h10][1], mem[8'h10][0]}, 32'hDEAD_BEEF);
    hostRd(A_FLAG, 32'h1, "R9 completion flag");
    chkEq("R11 masked completion flag", {31'b0, irq}, 32'h0);
    hostWr(A_EN, 32'h3);
    chkEq("R11 enabled completion flag", {31'b0, irq}, 32'h1);
    hostWr(A_FLAG, 32'h1);
    chkEq("R10 clear drops irq", {31'b0, irq}, 32'h0);
    hostRd(A_FLAG, 32'h0, "R10 flag cleared");
    hostWr(A_EN, 32'h2);

    // R3 / R6 read transfers
    hostWr(A_CTRL, 32'h010F_0022);
    chkEq("R3 request on read control", {31'b0, innerReq}, 32'h1);
    chkEq("R3 read direction", {31'b0, innerWe}, 32'h0);
    chkEq("R3 inner address", {24'b0, innerAddr}, 32'h22);
    chkEq("R3 inner lanes", {28'b0, innerBe}, 32'hF);
    hostRd(A_LOW, 32'hDEAD_BEEF, "R7 lower read during transfer");
    waitDone();
    hostRd(A_LOW, 32'h4433_2211, "R6 full read data");
    hostWr(A_CTRL, 32'h0101_0023);
    waitDone();
    hostRd(A_LOW, 32'h4433_22DD, "R6 partial lane merge");

    // R4 lower write with read direction stored
    hostWr(A_LOW, 32'h1234_5678);
    chkEq("R4 no transfer with read direction", {31'b0, innerReq}, 32'h0);
    hostRd(A_LOW, 32'h1234_5678, "R4 lower data loaded only");
    hostWr(A_FLAG, 32'h3);

    // R8 / R10 / R11 interrupt aggregation
    innerIrq = 1'b1;
    @(negedge clk);
    chkEq("R8 rising edge sets subsystem flag", {31'b0, irq}, 32'h1);
    hostWr(A_FLAG, 32'h2);
    @(negedge clk);
    hostRd(A_FLAG, 32'h0, "R8 steady level does not re-set flag");
    chkEq("R10 cleared subsystem flag", {31'b0, irq}, 32'h0);
    innerIrq = 1'b0;
    @(negedge clk);
    innerIrq = 1'b1;
    hostWr(A_FLAG, 32'h2);
    hostRd(A_FLAG, 32'h2, "R10 set wins over clear");
    hostWr(A_EN, 32'h0);
    chkEq("R11 disabled flag masked", {31'b0, irq}, 32'h0);
    hostWr(A_EN, 32'h1);
    chkEq("R11 other enable masked", {31'b0, irq}, 32'h0);

    repeat (3) @(negedge clk);
    chkEq("scoreboard drained", expQ.size(), 32'h0);
    finishRun();
  end
endmodule